// File: doc/BRIEF.md
# Subnormal Product Renormalizer

This stage sits directly after a 24x24-bit significand multiplier in a mixed-precision multiply-add datapath. Each operand is a binary32 value: a 24-bit significand whose top bit is the hidden bit, cleared when the operand is subnormal, and an 8-bit biased exponent field. Every product of two binary32 values lands inside the binary64 normal range, so the raw 48-bit product never needs rounding here. It only needs to be brought into normalized form and given a binary64 biased exponent.

The shift distance is not taken from the product. Leading zeros are counted on the two input significands, in parallel with the multiplier, and the product is shifted left by their sum. That shift leaves the leading one at bit 47 or bit 46. A final one-bit correction moves it to bit 47, and the exponent is adjusted to match. If either significand is zero, a zero flag is raised and the data outputs read zero. The result is registered once, with a valid qualifier.

Top module: `subnorm_prod_renorm`

## Requirements
- R1: When either significand is zero, the captured result has zero_o=1, prod_o=0 and exp_o=0.
- R2: For a nonzero result, bit 47 of prod_o is 1.
- R3: prod_o equals prod_i shifted left by (47 - m), where m is the index of the most significant set bit of prod_i. No set bit is lost. When both hidden bits are set and prod_i[47] is 1, prod_o equals prod_i unchanged.
- R4: For a nonzero result, exp_o = ea' + eb' + 723 + m. Here ea' and eb' are the exponent fields, with a field of 0 read as 1. This is the binary64 biased exponent of the exact product, with bias 1023.
- R5: An exponent field of 0 marks a subnormal operand. Its effective field is 1 and its hidden bit is 0, and this holds for either operand position.
- R6: Significands of 1 with fields of 0 give exp_o=725 (an exponent of -298) and prod_o = 1<<47.
- R7: valid_o is valid_i delayed by one clock. While valid_i is low, zero_o, prod_o and exp_o keep their values.
- R8: After reset, valid_o, zero_o, prod_o and exp_o are all 0.
- R9: A nonzero result has exp_o in 725..1278. Significands of 0xFFFFFF with fields of 254 give 1278, and prod_o equals prod_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands and product are valid |
| sig_a_i | input | 24 | Significand A, hidden bit at bit 23 |
| exp_a_i | input | 8 | Biased exponent field A |
| sig_b_i | input | 24 | Significand B, hidden bit at bit 23 |
| exp_b_i | input | 8 | Biased exponent field B |
| prod_i | input | 48 | Raw product sig_a_i * sig_b_i |
| valid_o | output | 1 | Result valid |
| zero_o | output | 1 | A significand was zero |
| prod_o | output | 48 | Normalized product, leading one at bit 47 |
| exp_o | output | 11 | Binary64 biased exponent of the product |

## Verification
The checks assume that prod_i is the exact product of the two significands presented in the same cycle. They also assume each hidden bit agrees with its exponent field: a field of 0 means hidden bit 0, and a nonzero field means hidden bit 1. The block derives its shift only from the significands, so a product that disagrees with them would break the leading-one and range properties. The bench therefore forms every prod_i as the multiplication of the significands it drives. It pairs each exponent field with a consistent hidden bit. It holds valid_i low through reset.

// File: rtl/renorm_pkg.sv
package renorm_pkg;
  localparam int unsigned DEF_SIG_W    = 24;
  localparam int unsigned DEF_EXP_W    = 8;
  localparam int unsigned DEF_BIAS_IN  = 127;
  localparam int unsigned DEF_OEXP_W   = 11;
  localparam int unsigned DEF_BIAS_OUT = 1023;

  // combined exponent offset: out bias - two in biases + 1 (product point at bit 46 -> 47)
  function automatic int exp_offset(input int bias_in, input int bias_out);
    return bias_out - 2 * bias_in + 1;
  endfunction
endpackage

// File: rtl/renorm_lzc.sv
module renorm_lzc #(
  parameter int unsigned W  = 24,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

  assign zero_o = ~|d_i;
endmodule

// File: rtl/renorm_lshift.sv
module renorm_lshift #(
  parameter int unsigned W  = 48,
  parameter int unsigned SW = 6
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  d_o
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = d_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  assign d_o = stg[SW];
endmodule

// File: rtl/renorm_exp.sv
module renorm_exp #(
  parameter int unsigned EXP_W    = 8,
  parameter int unsigned OEXP_W   = 11,
  parameter int unsigned BIAS_IN  = 127,
  parameter int unsigned BIAS_OUT = 1023,
  parameter int unsigned SH_W     = 6
) (
  input  logic [EXP_W-1:0]  ea_i,
  input  logic [EXP_W-1:0]  eb_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [OEXP_W-1:0] exp_o
);
  import renorm_pkg::*;

  localparam int          OFS = exp_offset(BIAS_IN, BIAS_OUT);
  localparam int unsigned XW  = OEXP_W + 2;

  logic [XW-1:0] ea_x, eb_x, sum;

  // subnormal field 0 behaves as field 1
  assign ea_x = (ea_i == '0) ? XW'(1) : XW'(ea_i);
  assign eb_x = (eb_i == '0) ? XW'(1) : XW'(eb_i);
  assign sum  = ea_x + eb_x + XW'(OFS) - XW'(shamt_i);
  assign exp_o = sum[OEXP_W-1:0];
endmodule

// File: rtl/subnorm_prod_renorm.sv
module subnorm_prod_renorm #(
  parameter int unsigned SIG_W    = renorm_pkg::DEF_SIG_W,
  parameter int unsigned EXP_W    = renorm_pkg::DEF_EXP_W,
  parameter int unsigned BIAS_IN  = renorm_pkg::DEF_BIAS_IN,
  parameter int unsigned OEXP_W   = renorm_pkg::DEF_OEXP_W,
  parameter int unsigned BIAS_OUT = renorm_pkg::DEF_BIAS_OUT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SIG_W-1:0]     sig_a_i,
  input  logic [EXP_W-1:0]     exp_a_i,
  input  logic [SIG_W-1:0]     sig_b_i,
  input  logic [EXP_W-1:0]     exp_b_i,
  input  logic [2*SIG_W-1:0]   prod_i,
  output logic                 valid_o,
  output logic                 zero_o,
  output logic [2*SIG_W-1:0]   prod_o,
  output logic [OEXP_W-1:0]    exp_o
);
  localparam int unsigned PROD_W = 2 * SIG_W;
  localparam int unsigned LZC_W  = $clog2(SIG_W + 1);
  localparam int unsigned SH_W   = $clog2(PROD_W + 1);

  logic [LZC_W-1:0]  cnt_a, cnt_b;
  logic              zero_a, zero_b, is_zero, fix;
  logic [SH_W-1:0]   shamt, tot;
  logic [PROD_W-1:0] pre, norm;
  logic [OEXP_W-1:0] exp_c;

  // counts run beside the multiplier, not on its output
  renorm_lzc #(.W(SIG_W), .CW(LZC_W)) u_lzc_a (
    .d_i(sig_a_i), .cnt_o(cnt_a), .zero_o(zero_a)
  );
  renorm_lzc #(.W(SIG_W), .CW(LZC_W)) u_lzc_b (
    .d_i(sig_b_i), .cnt_o(cnt_b), .zero_o(zero_b)
  );

  assign shamt   = SH_W'(cnt_a) + SH_W'(cnt_b);
  assign is_zero = zero_a | zero_b;

  renorm_lshift #(.W(PROD_W), .SW(SH_W)) u_shift (
    .d_i(prod_i), .amt_i(shamt), .d_o(pre)
  );

  // leading one is at PROD_W-1 or PROD_W-2 after the coarse shift
  assign fix  = ~pre[PROD_W-1];
  assign norm = fix ? {pre[PROD_W-2:0], 1'b0} : pre;
  assign tot  = shamt + SH_W'(fix);

  renorm_exp #(
    .EXP_W(EXP_W), .OEXP_W(OEXP_W), .BIAS_IN(BIAS_IN),
    .BIAS_OUT(BIAS_OUT), .SH_W(SH_W)
  ) u_exp (
    .ea_i(exp_a_i), .eb_i(exp_b_i), .shamt_i(tot), .exp_o(exp_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      zero_o  <= 1'b0;
      prod_o  <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        zero_o <= is_zero;
        prod_o <= is_zero ? '0 : norm;
        exp_o  <= is_zero ? '0 : exp_c;
      end
    end
  end
endmodule

// File: rtl/subnorm_prod_renorm_chk.sv
module subnorm_prod_renorm_chk #(
  parameter int unsigned SIG_W    = 24,
  parameter int unsigned EXP_W    = 8,
  parameter int unsigned BIAS_IN  = 127,
  parameter int unsigned OEXP_W   = 11,
  parameter int unsigned BIAS_OUT = 1023
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [SIG_W-1:0]     sig_a_i,
  input logic [SIG_W-1:0]     sig_b_i,
  input logic [2*SIG_W-1:0]   prod_i,
  input logic                 valid_o,
  input logic                 zero_o,
  input logic [2*SIG_W-1:0]   prod_o,
  input logic [OEXP_W-1:0]    exp_o
);
  localparam int unsigned PROD_W = 2 * SIG_W;
  localparam int          OFS    = renorm_pkg::exp_offset(BIAS_IN, BIAS_OUT);
  localparam int          EXP_LO = 2 + OFS - int'(PROD_W - 1);
  localparam int          EXP_HI = 2 * ((1 << EXP_W) - 2) + OFS;

  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (sig_a_i == '0 || sig_b_i == '0) |=> zero_o); // R1

  AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && zero_o |-> (prod_o == '0) && (exp_o == '0)); // R1

  AST_LEAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !zero_o |-> prod_o[PROD_W-1]); // R2

  AST_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sig_a_i[SIG_W-1] && sig_b_i[SIG_W-1] && prod_i[PROD_W-1]
    |=> prod_o == $past(prod_i)); // R3

  AST_VALID_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7

  AST_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(prod_o) && $stable(exp_o) && $stable(zero_o)); // R7

  AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !zero_o |-> (int'(exp_o) >= EXP_LO) && (int'(exp_o) <= EXP_HI)); // R9
endmodule

bind subnorm_prod_renorm subnorm_prod_renorm_chk #(
  .SIG_W(SIG_W), .EXP_W(EXP_W), .BIAS_IN(BIAS_IN),
  .OEXP_W(OEXP_W), .BIAS_OUT(BIAS_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .sig_a_i(sig_a_i), .sig_b_i(sig_b_i), .prod_i(prod_i),
  .valid_o(valid_o), .zero_o(zero_o), .prod_o(prod_o), .exp_o(exp_o)
);

// File: tb/subnorm_prod_renorm_tb_top.sv
module subnorm_prod_renorm_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] sig_a_i = '0, sig_b_i = '0;
  logic [7:0]  exp_a_i = '0, exp_b_i = '0;
  logic [47:0] prod_i = '0;
  logic        valid_o, zero_o;
  logic [47:0] prod_o;
  logic [10:0] exp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  subnorm_prod_renorm dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .sig_a_i(sig_a_i), .exp_a_i(exp_a_i), .sig_b_i(sig_b_i), .exp_b_i(exp_b_i),
    .prod_i(prod_i), .valid_o(valid_o), .zero_o(zero_o), .prod_o(prod_o), .exp_o(exp_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference from the requirements: exact product, msb index m
  task automatic run_op(input string req, input logic [23:0] a, input logic [7:0] ea,
                        input logic [23:0] b, input logic [7:0] eb);
    logic [47:0] p, e_prod;
    int m, e_exp, eaf, ebf;
    bit z;
    p = {24'b0, a} * {24'b0, b};
    z = (a == 0) || (b == 0);
    m = 0;
    for (int i = 0; i < 48; i++) if (p[i]) m = i;
    eaf = (ea == 0) ? 1 : int'(ea);
    ebf = (eb == 0) ? 1 : int'(eb);
    e_prod = z ? 48'h0 : (p << (47 - m));
    e_exp  = z ? 0 : eaf + ebf + 723 + m;
    @(negedge clk_i);
    sig_a_i = a; exp_a_i = ea; sig_b_i = b; exp_b_i = eb; prod_i = p; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, 64'(valid_o), 64'(1));
    check({req, " zero"},  64'(zero_o), 64'(z));
    check({req, " prod"},  64'(prod_o), 64'(e_prod));
    check({req, " exp"},   64'(exp_o), 64'(e_exp));
  endtask

  task automatic t_reset();
    check("R8 valid", 64'(valid_o), 64'(0));
    check("R8 zero",  64'(zero_o), 64'(0));
    check("R8 prod",  64'(prod_o), 64'(0));
    check("R8 exp",   64'(exp_o), 64'(0));
  endtask

  task automatic t_hold();
    logic [47:0] pk;
    logic [10:0] ek;
    run_op("R4 hold setup", 24'hA00000, 8'd140, 24'h900001, 8'd100);
    pk = prod_o; ek = exp_o;
    sig_a_i = 24'h000003; exp_a_i = 8'd0; prod_i = 48'h5; sig_b_i = 24'h0; // valid_i stays low
    @(negedge clk_i);
    check("R7 valid drop", 64'(valid_o), 64'(0));
    check("R7 prod hold",  64'(prod_o), 64'(pk));
    check("R7 exp hold",   64'(exp_o), 64'(ek));
    check("R7 zero hold",  64'(zero_o), 64'(0));
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 24; i++) begin
      run_op("R3 R5 sweep A", 24'(1) << i, (i == 23) ? 8'd1 : 8'd0, 24'hC00001, 8'd130);
      run_op("R3 R5 sweep B", 24'hB00007, 8'd60, 24'(1) << i, (i == 23) ? 8'd1 : 8'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R7 watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    run_op("R4 R3 normal top", 24'hFFF000, 8'd127, 24'hE00001, 8'd127);
    run_op("R2 R4 one by one", 24'h800000, 8'd127, 24'h800000, 8'd127);
    run_op("R5 sub times normal", 24'h000A13, 8'd0, 24'h812345, 8'd200);
    run_op("R6 smallest", 24'h000001, 8'd0, 24'h000001, 8'd0);
    run_op("R9 largest", 24'hFFFFFF, 8'd254, 24'hFFFFFF, 8'd254);
    run_op("R1 zero a", 24'h000000, 8'd0, 24'h9ABCDE, 8'd90);
    run_op("R1 zero b", 24'h812345, 8'd33, 24'h000000, 8'd0);
    run_op("R2 sub times sub", 24'h7FFFFF, 8'd0, 24'h400000, 8'd0);
    t_hold();
    t_sweep();
    finish_run();
  end
endmodule